// File: doc/BRIEF.md
# Interrupt Status Coalescing Controller

This block gathers internal event pulses into a 32-bit status register and drives one host interrupt line. The host reads and writes it over a small 32-bit register bus with per-byte write enables. A status bit is cleared when the host writes a one to it. An enable mask selects which status bits may reach the interrupt line.

The line is not raised as soon as an enabled event arrives. A coalescing timer first counts a programmable number of 32 µs ticks, so that further events can collect and be serviced together. A tick prescaler, sized from the clock frequency parameter, produces those ticks. A high-priority receive pulse skips the wait. A second byte in the timing register programs a self-generated periodic event. That event sets its own status bit after each programmed number of ticks.

Register map (byte addresses): 0x0 timing register, with the coalescing timeout in byte 0 and the periodic count in byte 1. 0x4 is the status register, where writing a one clears a bit. 0x8 is the enable mask. Any other address reads as zero.

Top module: `intr_coalescer`

## Requirements
- R1: After reset the timing register reads 0x00000040 (timeout 64 ticks, periodic off), status and mask read 0, and the interrupt line is low.
- R2: A pulse on an event input bit sets the matching status bit. Only bits 31, 29, 28, 27, 25, 7, 1 and 0 are implemented; pulses on any other bit leave it reading 0.
- R3: Writing address 0x4 clears every status bit whose write-data bit is 1 within an enabled byte lane. Bits written with 0 keep their value. An event arriving in the same cycle as a clear of that bit leaves the bit set.
- R4: Status bits whose mask bit is 0 never raise the interrupt line.
- R5: With timeout N > 0, the line rises exactly N×T+1 clock edges after the edge that latched the first enabled pending bit, where T is the tick period in clocks (CLK_HZ/1e6×32).
- R6: With timeout 0, the line rises one clock edge after the enabled status bit is latched.
- R7: When mask bit 31 is set, a high-priority pulse sets status bit 31 and raises the line at the same edge, whatever the timeout.
- R8: The line falls at the edge where the host clears the last enabled pending bit. A later enabled event starts a fresh full timeout.
- R9: A nonzero periodic count P sets status bit 28 P×T edges after the write to byte 1 of address 0x0, and again every P×T edges after that. P = 0 stops the periodic event.
- R10: Byte enables select the lanes a write changes. Writing only byte 1 of address 0x0 leaves the timeout byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte address of the register |
| busBe | input | 4 | Per-byte write enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| evtPulse | input | 32 | One-cycle event pulses, one per status bit |
| hiPrioEvt | input | 1 | High-priority receive pulse that bypasses the coalescing delay |
| irqOut | output | 1 | Host interrupt line |

## Verification
Register writes and event pulses take effect at the next rising edge. Read data is combinational, so the bench reads it half a cycle after each edge. The interrupt line follows the latched status at the same edge in the bypass and clear cases. It follows one edge later for a zero timeout, and N×T+1 edges after the latching edge when the timer runs. The periodic bit appears P×T edges after the write edge. All stimulus is driven on the falling edge, and the bench waits a counted number of falling edges before sampling. Each timed result is checked both one edge before it is due, where it must still be absent, and on the edge where it is due.

// File: rtl/intr_coal_pkg.sv
`timescale 1ns/1ps
package intr_coal_pkg;

  localparam logic [31:0] EVT_IMPL_MASK = 32'hBA00_0083;
  localparam int unsigned HIPRIO_BIT    = 31;
  localparam int unsigned PERIODIC_BIT  = 28;
  localparam logic [7:0]  TIMEOUT_RST   = 8'h40;

  typedef enum logic [1:0] {
    CO_IDLE,
    CO_ARMED,
    CO_FIRED
  } coalState_e;

  // datapath -> control
  typedef struct packed {
    logic       pendingAny;
    logic       hiPrioHit;
    logic       perRestart;
    logic [7:0] timeout;
    logic [7:0] perVal;
  } dpInfo_t;

  // control -> datapath
  typedef struct packed {
    logic setPeriodic;
  } ctlStrobe_t;

endpackage

// File: rtl/intr_tick_gen.sv
`timescale 1ns/1ps
module intr_tick_gen #(
  parameter int unsigned DIV = 1600
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       cnt <= '0;
    else if (restart || cnt == LAST) cnt <= '0;
    else                             cnt <= cnt + CW'(1);
  end

  assign tick = (cnt == LAST);

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST); // R5

endmodule

// File: rtl/intr_coal_regs.sv
`timescale 1ns/1ps
module intr_coal_regs
  import intr_coal_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       evtPulse,
  input  logic              hiPrioEvt,
  input  ctlStrobe_t        ctl,
  output dpInfo_t           info
);
  localparam logic [ADDR_W-1:0] A_COAL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8);

  logic [31:0] statusQ, maskQ;
  logic [7:0]  timeoutQ, perQ;
  logic [31:0] beMask, setVec, clrVec;
  logic        wrCoal, wrStat, wrMask;

  for (genvar g = 0; g < 4; g++) begin : gLane
    assign beMask[8*g +: 8] = {8{busBe[g]}};
  end

  assign wrCoal = busWe && (busAddr == A_COAL);
  assign wrStat = busWe && (busAddr == A_STAT);
  assign wrMask = busWe && (busAddr == A_MASK);

  always_comb begin
    setVec = evtPulse;
    setVec[PERIODIC_BIT] = setVec[PERIODIC_BIT] | ctl.setPeriodic;
    setVec[HIPRIO_BIT]   = setVec[HIPRIO_BIT] | hiPrioEvt;
    setVec = setVec & EVT_IMPL_MASK;
  end

  assign clrVec = wrStat ? (busWdata & beMask) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      maskQ    <= '0;
      timeoutQ <= TIMEOUT_RST;
      perQ     <= '0;
    end else begin
      statusQ <= (statusQ & ~clrVec) | setVec;
      if (wrMask) maskQ <= (maskQ & ~beMask) | (busWdata & beMask);
      if (wrCoal && busBe[0]) timeoutQ <= busWdata[7:0];
      if (wrCoal && busBe[1]) perQ     <= busWdata[15:8];
    end
  end

  always_comb begin
    case (busAddr)
      A_COAL:  busRdata = {16'h0, perQ, timeoutQ};
      A_STAT:  busRdata = statusQ;
      A_MASK:  busRdata = maskQ;
      default: busRdata = '0;
    endcase
  end

  assign info.pendingAny = |(statusQ & maskQ);
  assign info.hiPrioHit  = hiPrioEvt & maskQ[HIPRIO_BIT];
  assign info.perRestart = wrCoal & busBe[1];
  assign info.timeout    = timeoutQ;
  assign info.perVal     = perQ;

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~EVT_IMPL_MASK) == 32'h0); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && busBe[0] && busWdata[0] && !evtPulse[0]) |=> !statusQ[0]); // R3

  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && busBe[0] && !busWdata[0] && statusQ[0]) |=> statusQ[0]); // R3

  AST_PERIODIC_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[PERIODIC_BIT]) |-> ($past(perQ) != 8'h0 || $past(evtPulse[PERIODIC_BIT]))); // R9

  AST_TIMEOUT_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (wrCoal && !busBe[0]) |=> $stable(timeoutQ)); // R10

endmodule

// File: rtl/intr_coal_ctrl.sv
`timescale 1ns/1ps
module intr_coal_ctrl
  import intr_coal_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpInfo_t    info,
  output ctlStrobe_t ctl,
  output logic       irqOut
);
  coalState_e state;
  logic [7:0] tmrCnt, perCnt;
  logic       coalTick, perTick, coalRestart, setPer;

  assign coalRestart = (state == CO_IDLE);

  intr_tick_gen #(.DIV(TICK_DIV)) uCoalTick (
    .clk(clk), .rstN(rstN), .restart(coalRestart), .tick(coalTick)
  );

  intr_tick_gen #(.DIV(TICK_DIV)) uPerTick (
    .clk(clk), .rstN(rstN), .restart(info.perRestart), .tick(perTick)
  );

  // coalescing timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= CO_IDLE;
      tmrCnt <= '0;
    end else begin
      case (state)
        CO_IDLE: begin
          if (info.hiPrioHit) state <= CO_FIRED;
          else if (info.pendingAny) begin
            if (info.timeout == 8'h0) state <= CO_FIRED;
            else begin
              state  <= CO_ARMED;
              tmrCnt <= info.timeout;
            end
          end
        end
        CO_ARMED: begin
          if (info.hiPrioHit)       state <= CO_FIRED;
          else if (!info.pendingAny) state <= CO_IDLE;
          else if (coalTick) begin
            if (tmrCnt == 8'h1) state <= CO_FIRED;
            else                tmrCnt <= tmrCnt - 8'h1;
          end
        end
        CO_FIRED: begin
          if (!info.pendingAny && !info.hiPrioHit) state <= CO_IDLE;
        end
        default: state <= CO_IDLE;
      endcase
    end
  end

  // periodic event
  assign setPer = perTick && (info.perVal != 8'h0) && (perCnt == info.perVal - 8'h1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 perCnt <= '0;
    else if (info.perRestart)  perCnt <= '0;
    else if (perTick) begin
      if (setPer) perCnt <= '0;
      else        perCnt <= perCnt + 8'h1;
    end
  end

  assign ctl.setPeriodic = setPer;
  assign irqOut = (state == CO_FIRED) && info.pendingAny;

  AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (state == CO_ARMED) |-> (tmrCnt != 8'h0)); // R5

  AST_ZERO_TIMEOUT_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (state == CO_IDLE && info.pendingAny && info.timeout == 8'h0) |=> (state == CO_FIRED)); // R6

  AST_HIPRIO_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    info.hiPrioHit |=> (state == CO_FIRED)); // R7

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    !info.pendingAny |-> !irqOut); // R8

  AST_FIRED_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (state == CO_FIRED && !info.pendingAny && !info.hiPrioHit) |=> (state == CO_IDLE)); // R8

endmodule

// File: rtl/intr_coalescer.sv
`timescale 1ns/1ps
module intr_coalescer
  import intr_coal_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned TICK_US = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       evtPulse,
  input  logic              hiPrioEvt,
  output logic              irqOut
);
  localparam int unsigned TICK_DIV = (CLK_HZ / 1_000_000) * TICK_US;

  dpInfo_t    info;
  ctlStrobe_t ctl;

  intr_coal_regs #(.ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .evtPulse(evtPulse),
    .hiPrioEvt(hiPrioEvt), .ctl(ctl), .info(info)
  );

  intr_coal_ctrl #(.TICK_DIV(TICK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .info(info), .ctl(ctl), .irqOut(irqOut)
  );

endmodule

// File: tb/intr_coalescer_test.sv
`timescale 1ns/1ps
module intr_coalescer_test;
  localparam int T = 1600; // clocks per tick at 50 MHz

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] evtPulse = '0;
  logic        hiPrioEvt = 1'b0;
  logic        irqOut;

  int testCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;

  intr_coalescer uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .evtPulse(evtPulse),
    .hiPrioEvt(hiPrioEvt), .irqOut(irqOut)
  );

  // {event, clear, expected status}
  localparam logic [95:0] VECS [0:5] = '{
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
    {32'h0800_0080, 32'h0000_0000, 32'h0800_0081},
    {32'h0000_0000, 32'h0000_0001, 32'h0800_0080},
    {32'h0400_0000, 32'h0000_0000, 32'h0800_0080},
    {32'h2000_0002, 32'h0000_0080, 32'h2800_0002},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busBe = be; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busBe = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    evtPulse = v;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);

    // R1 reset state
    busRead(4'h0, rd); check("R1 timing", rd, 32'h0000_0040);
    busRead(4'h4, rd); check("R1 status", rd, 32'h0);
    busRead(4'h8, rd); check("R1 mask", rd, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // vector table: R2 / R3 / R4 with mask 0
    for (int i = 0; i < 6; i++) begin
      if (VECS[i][95:64] != 32'h0) pulse(VECS[i][95:64]);
      if (VECS[i][63:32] != 32'h0) busWrite(4'h4, 4'hF, VECS[i][63:32]);
      busRead(4'h4, rd);
      check("R2/R3 status vector", rd, VECS[i][31:0]);
      check("R4 irq masked", {31'b0, irqOut}, 32'h0);
    end

    // R3 set wins over same-cycle clear
    pulse(32'h1);
    @(negedge clk);
    evtPulse = 32'h1; busWe = 1'b1; busAddr = 4'h4; busBe = 4'hF; busWdata = 32'h1;
    @(negedge clk);
    evtPulse = '0; busWe = 1'b0; busBe = '0;
    busRead(4'h4, rd); check("R3 set wins", rd, 32'h1);
    busWrite(4'h4, 4'hF, 32'h1);
    busRead(4'h4, rd); check("R3 cleared", rd, 32'h0);

    // R5 coalescing delay, timeout 2
    busWrite(4'h0, 4'h1, 32'h2);
    busWrite(4'h8, 4'hF, 32'h3);
    pulse(32'h1);
    check("R5 irq right after event", {31'b0, irqOut}, 32'h0);
    waitEdges(2 * T);
    check("R5 irq one edge early", {31'b0, irqOut}, 32'h0);
    waitEdges(1);
    check("R5 irq due", {31'b0, irqOut}, 32'h1);

    // R8 clear drops line, re-arm with timeout 1
    busWrite(4'h4, 4'hF, 32'h1);
    check("R8 irq drops on clear", {31'b0, irqOut}, 32'h0);
    busWrite(4'h0, 4'h1, 32'h1);
    pulse(32'h2);
    waitEdges(T);
    check("R8 rearm one edge early", {31'b0, irqOut}, 32'h0);
    waitEdges(1);
    check("R8 rearm due", {31'b0, irqOut}, 32'h1);
    busWrite(4'h4, 4'hF, 32'h2);
    check("R8 irq drops again", {31'b0, irqOut}, 32'h0);

    // R6 zero timeout
    busWrite(4'h0, 4'h1, 32'h0);
    pulse(32'h2);
    check("R6 irq at latch edge", {31'b0, irqOut}, 32'h0);
    waitEdges(1);
    check("R6 irq next edge", {31'b0, irqOut}, 32'h1);
    busWrite(4'h4, 4'hF, 32'h2);
    check("R6 irq cleared", {31'b0, irqOut}, 32'h0);

    // R4 masked bit with zero timeout
    busWrite(4'h8, 4'hF, 32'h0);
    pulse(32'h80);
    waitEdges(5);
    check("R4 masked irq", {31'b0, irqOut}, 32'h0);
    busRead(4'h4, rd); check("R4 status still set", rd, 32'h80);
    busWrite(4'h4, 4'hF, 32'h80);

    // R7 high-priority bypass with default timeout
    busWrite(4'h0, 4'h1, 32'h40);
    busWrite(4'h8, 4'hF, 32'h8000_0000);
    @(negedge clk); hiPrioEvt = 1'b1;
    @(negedge clk); hiPrioEvt = 1'b0;
    check("R7 irq immediate", {31'b0, irqOut}, 32'h1);
    busRead(4'h4, rd); check("R7 status bit31", rd, 32'h8000_0000);
    busWrite(4'h4, 4'h8, 32'h8000_0000);
    check("R7 irq cleared", {31'b0, irqOut}, 32'h0);

    // R9 / R10 periodic event
    busWrite(4'h0, 4'h2, 32'h0000_0100);
    waitEdges(T - 1);
    busRead(4'h4, rd); check("R9 periodic early", rd, 32'h0);
    waitEdges(1);
    busRead(4'h4, rd); check("R9 periodic due", rd, 32'h1000_0000);
    busRead(4'h0, rd); check("R10 timeout lane kept", rd, 32'h0000_0140);
    busWrite(4'h0, 4'h2, 32'h0);
    busWrite(4'h4, 4'hF, 32'h1000_0000);
    waitEdges(2 * T + 100);
    busRead(4'h4, rd); check("R9 periodic off", rd, 32'h0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule